// File: doc/BRIEF.md
# Block Security Table Register File

This block is the configuration register file of a filter that marks each fixed-size block of a memory region as secure-only or non-secure-only. Software reaches it through a simple 32-bit request bus that carries a byte, halfword or word size and a secure attribute. Behind this bus sit a control word, an index pointer, and a table holding one security bit per memory block, packed 32 blocks per word. There are also interrupt status, enable and violation-capture registers, and a set of read-only identification bytes. The table bits and two control bits go straight out to the filter datapath. Violation reports come back in on a side input and raise the interrupt.

Software normally sets the index once and then streams table words through the single table window, letting the index step itself after every full-word access. The error-response and auto-step bits are held in a small lock state machine with two states, `LK_OPEN` and `LK_SEALED`. The `seal` transition, from `LK_OPEN` to `LK_SEALED`, fires on a control write that has bit 31 set. `LK_SEALED` has only the self-loop `hold`; the only way back to `LK_OPEN` is a reset. Read data comes back registered, one cycle after the request, flagged by `rsp_valid`. Writes take effect at the clock edge where the request is sampled.

Top module: `mpcr_regs`

## Requirements
- R1: After reset, the register at 0x00 reads 0x00000100, the enable register at 0x28 reads 1, and every other state reads zero: the index at 0x18, the status at 0x20, the capture words at 0x2C and 0x30, and every table word. The outputs `irq` and `cfg_locked` are 0.
- R2: In the control word at 0x00, only bit 4 (error response, driven on `cfg_err_resp`), bit 8 (auto-step) and bit 31 (lock, driven on `cfg_locked`) hold a value. All other bits read as zero and ignore writes.
- R3: Offset 0x10 reads LUT_WORDS-1. Offset 0x14 reads BLK_LOG2-5.
- R4: A write to the index at 0x18 stores the written 32-bit value modulo LUT_WORDS.
- R5: Offset 0x1C reads and writes the table word selected by the index. Table word k drives `lut_bits[32k+31:32k]`.
- R6: When auto-step is set, a word-sized (size 2) read or accepted write at 0x1C advances the index by one, wrapping from LUT_WORDS-1 to 0. Byte (size 0) and halfword (size 1) accesses never advance it.
- R7: A non-secure request to any offset below 0xFD0 reads as zero and changes no state. This includes the index, which does not step.
- R8: Once the lock bit is written as 1, writes to 0x00, 0x1C and 0x28 are ignored until reset. Other registers stay writable.
- R9: The byte lane is address bits [1:0], and the write data is right-aligned. A byte or halfword write to 0x00, 0x18 or 0x1C is merged into the current contents at that lane. Such a write to any other offset is first zero-extended to a full word.
- R10: A byte or halfword read returns the addressed bytes of the full register word, shifted down to bit 0. Reads of 0x24, 0x34 and of unmapped offsets return zero.
- R11: Writing 1 in bit 0 of 0x34 sets the status bit, and writing 1 in bit 0 of 0x24 clears it. `irq` equals status AND enable. A set or a capture in the same cycle wins over a clear.
- R12: A `viol_valid` pulse while the status bit is 0 loads `viol_addr` into 0x2C and `viol_info` into 0x30, and sets the status bit. Pulses that arrive while the status bit is 1 leave the capture words unchanged.
- R13: The twelve word offsets 0xFD0 to 0xFFC read, in address order, as the bytes 04 00 00 00 60 B8 1B 00 0D F0 05 B1. They are readable by both secure and non-secure requests, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Secure attribute of the request |
| req_addr | input | 12 | Byte address within the 4 KiB register window |
| req_size | input | 2 | 0 = byte, 1 = halfword, 2 = word |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data, right-aligned |
| viol_valid | input | 1 | Blocked-transfer report from the filter |
| viol_addr | input | 32 | Address of the blocked transfer |
| viol_info | input | 32 | Requester attributes of the blocked transfer |
| irq | output | 1 | Interrupt: status AND enable |
| cfg_err_resp | output | 1 | Error-response control bit |
| cfg_locked | output | 1 | Register file is sealed |
| lut_bits | output | LUT_WORDS*32 | Flattened security table |

## Verification
The bench builds the block with LUT_WORDS=4 and BLK_LOG2=12. With four table words, a run of four auto-stepped writes reaches the index wrap. The modulo on an index write is also visible with small values such as 6 and 0xFFFFFFFF. A block size of 4 KiB gives the geometry register a non-trivial value of 7. A behavioural model in the bench follows every clock and compares the registered read data, `irq`, the exported control bits and all four table words. This covers the sealed state, non-secure requests and violation reports that arrive while the status bit is already set.

// File: rtl/mpcr_pkg.sv
package mpcr_pkg;

    localparam logic [11:0] OFS_CTRL  = 12'h000;
    localparam logic [11:0] OFS_BMAX  = 12'h010;
    localparam logic [11:0] OFS_BCFG  = 12'h014;
    localparam logic [11:0] OFS_BIDX  = 12'h018;
    localparam logic [11:0] OFS_BLUT  = 12'h01C;
    localparam logic [11:0] OFS_ISTAT = 12'h020;
    localparam logic [11:0] OFS_ICLR  = 12'h024;
    localparam logic [11:0] OFS_IEN   = 12'h028;
    localparam logic [11:0] OFS_INFO1 = 12'h02C;
    localparam logic [11:0] OFS_INFO2 = 12'h030;
    localparam logic [11:0] OFS_ISET  = 12'h034;
    localparam logic [11:0] OFS_ID_LO = 12'hFD0;

    localparam int CTRL_ERR_BIT  = 4;
    localparam int CTRL_STEP_BIT = 8;
    localparam int CTRL_SEAL_BIT = 31;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lock_state_e;

    function automatic logic [31:0] lane_mask(input logic [1:0] size);
        case (size)
            2'd0:    lane_mask = 32'h0000_00FF;
            2'd1:    lane_mask = 32'h0000_FFFF;
            default: lane_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                               input logic [31:0] val,
                                               input logic [1:0]  lane,
                                               input logic [1:0]  size);
        logic [31:0] m;
        logic [4:0]  sh;
        m  = lane_mask(size);
        sh = {lane, 3'b000};
        if (size >= 2'd2) lane_merge = val;
        else lane_merge = (old_w & ~(m << sh)) | ((val & m) << sh);
    endfunction

    function automatic logic [31:0] lane_pick(input logic [31:0] word,
                                              input logic [1:0]  lane,
                                              input logic [1:0]  size);
        logic [4:0] sh;
        sh = {lane, 3'b000};
        if (size >= 2'd2) lane_pick = word;
        else lane_pick = (word >> sh) & lane_mask(size);
    endfunction

    function automatic logic [7:0] id_byte(input logic [3:0] k);
        case (k)
            4'd0:  id_byte = 8'h04;
            4'd4:  id_byte = 8'h60;
            4'd5:  id_byte = 8'hB8;
            4'd6:  id_byte = 8'h1B;
            4'd8:  id_byte = 8'h0D;
            4'd9:  id_byte = 8'hF0;
            4'd10: id_byte = 8'h05;
            4'd11: id_byte = 8'hB1;
            default: id_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/mpcr_lock_fsm.sv
module mpcr_lock_fsm
    import mpcr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_we,
    input  logic [31:0] ctrl_wval,
    output logic        err_resp,
    output logic        autostep,
    output logic        sealed
);

    lock_state_e state_q, state_d;
    logic        err_q, step_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN:   if (ctrl_we && ctrl_wval[CTRL_SEAL_BIT]) state_d = LK_SEALED;
            LK_SEALED: state_d = LK_SEALED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            step_q <= 1'b1;
        end else if (ctrl_we && state_q == LK_OPEN) begin
            err_q  <= ctrl_wval[CTRL_ERR_BIT];
            step_q <= ctrl_wval[CTRL_STEP_BIT];
        end
    end

    always_comb begin
        sealed   = (state_q == LK_SEALED);
        err_resp = err_q;
        autostep = step_q;
    end

    // R8: the sealed state is only left through reset
    p_seal_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_SEALED) |=> (state_q == LK_SEALED));

    // R8: control bits are frozen while sealed
    p_ctrl_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sealed |=> ($stable(err_q) && $stable(step_q)));

endmodule

// File: rtl/mpcr_table.sv
module mpcr_table #(
    parameter int LUT_WORDS = 4,
    parameter int IDX_W     = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   idx_we,
    input  logic [31:0]            idx_wval,
    input  logic                   lut_we,
    input  logic [31:0]            lut_wval,
    input  logic                   step,
    output logic [IDX_W-1:0]       idx,
    output logic [31:0]            cur_word,
    output logic [LUT_WORDS*32-1:0] lut_bits
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(LUT_WORDS - 1);

    logic [31:0]      words [LUT_WORDS];
    logic [IDX_W-1:0] idx_q;
    logic [31:0]      idx_mod;

    assign idx_mod = idx_wval % 32'(LUT_WORDS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_we) idx_q <= idx_mod[IDX_W-1:0];
        else if (step)   idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end

    for (genvar g = 0; g < LUT_WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) words[g] <= '0;
            else if (lut_we && idx_q == IDX_W'(g)) words[g] <= lut_wval;
        end
        assign lut_bits[g*32 +: 32] = words[g];
    end

    assign idx      = idx_q;
    assign cur_word = words[idx_q];

    // R4: the index never leaves the table
    p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(idx_q) < 32'(LUT_WORDS)));

    // R6: stepping from the last word wraps to zero
    p_step_wraps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !idx_we && idx_q == LAST) |=> (idx_q == '0));

endmodule

// File: rtl/mpcr_irq.sv
module mpcr_irq (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_req,
    input  logic        clr_req,
    input  logic        en_we,
    input  logic        en_wval,
    input  logic        viol_valid,
    input  logic [31:0] viol_addr,
    input  logic [31:0] viol_info,
    output logic        stat,
    output logic        en,
    output logic [31:0] info1,
    output logic [31:0] info2,
    output logic        irq
);

    logic capture;
    assign capture = viol_valid && !stat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat  <= 1'b0;
            en    <= 1'b1;
            info1 <= '0;
            info2 <= '0;
        end else begin
            if (capture || set_req) stat <= 1'b1;
            else if (clr_req)       stat <= 1'b0;
            if (en_we) en <= en_wval;
            if (capture) begin
                info1 <= viol_addr;
                info2 <= viol_info;
            end
        end
    end

    assign irq = stat && en;

    // R12: capture words hold while the status is pending
    p_info_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stat |=> ($stable(info1) && $stable(info2)));

    // R11: a set request always leaves the status pending
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> stat);

endmodule

// File: rtl/mpcr_regs.sv
module mpcr_regs
    import mpcr_pkg::*;
#(
    parameter int LUT_WORDS = 4,
    parameter int BLK_LOG2  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic                    req_secure,
    input  logic [11:0]             req_addr,
    input  logic [1:0]              req_size,
    input  logic [31:0]             req_wdata,
    output logic                    rsp_valid,
    output logic [31:0]             rsp_rdata,
    input  logic                    viol_valid,
    input  logic [31:0]             viol_addr,
    input  logic [31:0]             viol_info,
    output logic                    irq,
    output logic                    cfg_err_resp,
    output logic                    cfg_locked,
    output logic [LUT_WORDS*32-1:0] lut_bits
);

    localparam int IDX_W = (LUT_WORDS > 1) ? $clog2(LUT_WORDS) : 1;

    logic [11:0]      off;
    logic [1:0]       lane;
    logic             acc_ok, wr_ok;
    logic             sealed, autostep, err_resp;
    logic [IDX_W-1:0] idx;
    logic [31:0]      cur_word, ctrl_word, rd_word, old_word, wval;
    logic             stat, en;
    logic [31:0]      info1, info2;
    logic [9:0]       id_sel;
    logic             ctrl_we, idx_we, lut_we, en_we, set_req, clr_req, step;

    assign off    = {req_addr[11:2], 2'b00};
    assign lane   = req_addr[1:0];
    assign acc_ok = req_valid && (req_secure || off >= OFS_ID_LO);
    assign wr_ok  = acc_ok && req_write;
    assign id_sel = off[11:2] - 10'h3F4;

    assign ctrl_word = {sealed, 22'b0, autostep, 3'b0, err_resp, 4'b0};

    always_comb begin
        case (off)
            OFS_CTRL: old_word = ctrl_word;
            OFS_BIDX: old_word = 32'(idx);
            OFS_BLUT: old_word = cur_word;
            default:  old_word = '0;
        endcase
        wval = lane_merge(old_word, req_wdata, lane, req_size);
    end

    always_comb begin
        case (off)
            OFS_CTRL:  rd_word = ctrl_word;
            OFS_BMAX:  rd_word = 32'(LUT_WORDS - 1);
            OFS_BCFG:  rd_word = 32'(BLK_LOG2 - 5);
            OFS_BIDX:  rd_word = 32'(idx);
            OFS_BLUT:  rd_word = cur_word;
            OFS_ISTAT: rd_word = {31'b0, stat};
            OFS_IEN:   rd_word = {31'b0, en};
            OFS_INFO1: rd_word = info1;
            OFS_INFO2: rd_word = info2;
            default:   rd_word = (off >= OFS_ID_LO) ? {24'b0, id_byte(id_sel[3:0])} : '0;
        endcase
    end

    assign ctrl_we = wr_ok && off == OFS_CTRL;
    assign idx_we  = wr_ok && off == OFS_BIDX;
    assign lut_we  = wr_ok && off == OFS_BLUT && !sealed;
    assign en_we   = wr_ok && off == OFS_IEN && !sealed;
    assign set_req = wr_ok && off == OFS_ISET && wval[0];
    assign clr_req = wr_ok && off == OFS_ICLR && wval[0];
    assign step    = autostep && req_size == SZ_WORD && acc_ok && off == OFS_BLUT
                     && (!req_write || !sealed);

    mpcr_lock_fsm u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (ctrl_we),
        .ctrl_wval (wval),
        .err_resp  (err_resp),
        .autostep  (autostep),
        .sealed    (sealed)
    );

    mpcr_table #(.LUT_WORDS(LUT_WORDS), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_we   (idx_we),
        .idx_wval (wval),
        .lut_we   (lut_we),
        .lut_wval (wval),
        .step     (step),
        .idx      (idx),
        .cur_word (cur_word),
        .lut_bits (lut_bits)
    );

    mpcr_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_req    (set_req),
        .clr_req    (clr_req),
        .en_we      (en_we),
        .en_wval    (wval[0]),
        .viol_valid (viol_valid),
        .viol_addr  (viol_addr),
        .viol_info  (viol_info),
        .stat       (stat),
        .en         (en),
        .info1      (info1),
        .info2      (info2),
        .irq        (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            if (req_valid && !req_write)
                rsp_rdata <= acc_ok ? lane_pick(rd_word, lane, req_size) : '0;
        end
    end

    assign cfg_err_resp = err_resp;
    assign cfg_locked   = sealed;

    // R7: a rejected non-secure write leaves table and control untouched
    p_ns_inert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_secure && off < OFS_ID_LO)
        |=> ($stable(lut_bits) && $stable(cfg_err_resp) && $stable(cfg_locked)));

    // R8: the table cannot change while sealed
    p_lut_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> $stable(lut_bits));

    // R10: every read is answered on the next cycle
    p_read_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

endmodule

// File: tb/mpcr_regs_tb_top.sv
module mpcr_regs_tb_top;

    localparam int LW = 4;
    localparam int BL = 12;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
    logic [11:0]       req_addr = '0;
    logic [1:0]        req_size = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic              viol_valid = 1'b0;
    logic [31:0]       viol_addr = '0, viol_info = '0;
    logic              irq, cfg_err_resp, cfg_locked;
    logic [LW*32-1:0]  lut_bits;

    mpcr_regs #(.LUT_WORDS(LW), .BLK_LOG2(BL)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_secure(req_secure), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .viol_valid(viol_valid), .viol_addr(viol_addr), .viol_info(viol_info),
        .irq(irq), .cfg_err_resp(cfg_err_resp), .cfg_locked(cfg_locked),
        .lut_bits(lut_bits)
    );

    int    n_chk = 0, n_bad = 0;
    bit    done = 0;
    string cur_tag = "R1";

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_lut [LW];
    int          m_idx;
    bit          m_err, m_step, m_seal, m_stat, m_en, m_rv;
    logic [31:0] m_info1, m_info2, m_rdata;

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] b_merge(input logic [31:0] o, input logic [31:0] d,
                                            input int ln, input logic [1:0] s);
        logic [31:0] r = o;
        int n = nbytes(s);
        if (n == 4) ln = 0;
        for (int b = 0; b < 4; b++)
            if (b >= ln && b < ln + n) r[b*8 +: 8] = d[(b-ln)*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] b_pick(input logic [31:0] w, input int ln, input logic [1:0] s);
        logic [31:0] r = '0;
        int n = nbytes(s);
        if (n == 4) return w;
        for (int b = 0; b < n; b++)
            if (ln + b < 4) r[b*8 +: 8] = w[(ln+b)*8 +: 8];
        return r;
    endfunction

    logic [7:0] idb [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h60, 8'hB8,
                             8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    function automatic logic [31:0] m_word(input int o);
        logic [31:0] ctl = '0;
        ctl[4] = m_err; ctl[8] = m_step; ctl[31] = m_seal;
        if (o >= 'hFD0) return {24'b0, idb[(o - 'hFD0) / 4]};
        case (o)
            'h00: return ctl;
            'h10: return LW - 1;
            'h14: return BL - 5;
            'h18: return m_idx;
            'h1C: return m_lut[m_idx];
            'h20: return {31'b0, m_stat};
            'h28: return {31'b0, m_en};
            'h2C: return m_info1;
            'h30: return m_info2;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        int          o, ln;
        bit          ok, old_stat;
        logic [31:0] cur, wv;
        if (!rst_n) begin
            for (int k = 0; k < LW; k++) m_lut[k] = '0;
            m_idx = 0; m_err = 0; m_step = 1; m_seal = 0; m_stat = 0; m_en = 1;
            m_info1 = 0; m_info2 = 0; m_rv = 0; m_rdata = 0;
        end else begin
            o  = int'(req_addr) & ~3;
            ln = int'(req_addr[1:0]);
            ok = req_secure || o >= 'hFD0;
            old_stat = m_stat;
            m_rv = req_valid && !req_write;
            if (req_valid) begin
                cur = m_word(o);
                if (!req_write) begin
                    m_rdata = ok ? b_pick(cur, ln, req_size) : 0;
                    if (ok && o == 'h1C && req_size == 2 && m_step) m_idx = (m_idx + 1) % LW;
                end else if (ok) begin
                    wv = b_merge((o == 'h00 || o == 'h18 || o == 'h1C) ? cur : 0, req_wdata, ln, req_size);
                    case (o)
                        'h00: if (!m_seal) begin m_err = wv[4]; m_step = wv[8]; m_seal = wv[31]; end
                        'h18: m_idx = int'(wv % 32'(LW));
                        'h1C: if (!m_seal) begin
                                  m_lut[m_idx] = wv;
                                  if (req_size == 2 && m_step) m_idx = (m_idx + 1) % LW;
                              end
                        'h24: if (wv[0]) m_stat = 0;
                        'h28: if (!m_seal) m_en = wv[0];
                        'h34: if (wv[0]) m_stat = 1;
                        default: ;
                    endcase
                end
            end
            if (viol_valid && !old_stat) begin
                m_info1 = viol_addr; m_info2 = viol_info; m_stat = 1;
            end
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk({cur_tag, " rsp_valid"}, {31'b0, rsp_valid}, {31'b0, m_rv});
            if (m_rv) chk({cur_tag, " rsp_rdata"}, rsp_rdata, m_rdata);
            chk({cur_tag, " irq"}, {31'b0, irq}, {31'b0, m_stat && m_en});
            chk({cur_tag, " cfg_err_resp"}, {31'b0, cfg_err_resp}, {31'b0, m_err});
            chk({cur_tag, " cfg_locked"}, {31'b0, cfg_locked}, {31'b0, m_seal});
            for (int k = 0; k < LW; k++)
                chk({cur_tag, " lut_bits"}, lut_bits[k*32 +: 32], m_lut[k]);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic bus(input bit wr, input logic [11:0] a, input logic [1:0] sz,
                       input logic [31:0] d, input bit sec);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_size = sz;
        req_wdata = d; req_secure = sec;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d, input bit sec = 1);
        bus(1, a, sz, d, sec);
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [1:0] sz,
                      input logic [31:0] exp, input bit sec = 1);
        bus(0, a, sz, 32'h0, sec);
        chk(tag, rsp_rdata, exp);
    endtask

    task automatic viol(input logic [31:0] a, input logic [31:0] i);
        @(negedge clk);
        viol_valid = 1; viol_addr = a; viol_info = i;
        @(negedge clk);
        viol_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        cur_tag = "R1";
        rd("R1 ctrl", 12'h000, 2, 32'h100);
        rd("R1 int_en", 12'h028, 2, 32'h1);
        rd("R1 index", 12'h018, 2, 0);
        rd("R1 status", 12'h020, 2, 0);
        rd("R1 info1", 12'h02C, 2, 0);
        rd("R1 info2", 12'h030, 2, 0);
        rd("R1 lut byte", 12'h01C, 0, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 locked", {31'b0, cfg_locked}, 0);

        cur_tag = "R3";
        rd("R3 words-1", 12'h010, 2, 3);
        rd("R3 geometry", 12'h014, 2, 7);

        cur_tag = "R13";
        for (int k = 0; k < 12; k++) rd("R13 id", 12'(12'hFD0 + 4*k), 2, {24'b0, idb[k]});
        wr(12'hFE0, 2, 32'hFF);
        rd("R13 id write ignored", 12'hFE0, 2, 32'h60);
        rd("R13 id non-secure", 12'hFF0, 2, 32'h0D, 0);

        cur_tag = "R2";
        wr(12'h000, 2, 32'h7FFF_FFFF);
        rd("R2 ctrl mask", 12'h000, 2, 32'h110);
        chk("R2 err out", {31'b0, cfg_err_resp}, 1);
        wr(12'h000, 2, 32'h0);
        rd("R2 ctrl clear", 12'h000, 2, 32'h0);

        cur_tag = "R4";
        wr(12'h018, 2, 6);
        rd("R4 idx mod", 12'h018, 2, 2);
        wr(12'h018, 2, 32'hFFFF_FFFF);
        rd("R4 idx mod max", 12'h018, 2, 3);

        cur_tag = "R6";
        wr(12'h000, 2, 32'h100);
        wr(12'h018, 2, 0);
        wr(12'h01C, 2, 32'hA5A5_0001);
        wr(12'h01C, 2, 32'h0F0F_0002);
        wr(12'h01C, 2, 32'hC3C3_0003);
        wr(12'h01C, 2, 32'h8000_0004);
        rd("R6 wrap", 12'h018, 2, 0);
        chk("R5 lut0", lut_bits[31:0],   32'hA5A5_0001);
        chk("R5 lut3", lut_bits[127:96], 32'h8000_0004);
        rd("R5 lut read", 12'h01C, 2, 32'hA5A5_0001);
        rd("R6 read steps", 12'h018, 2, 1);
        rd("R6 byte read", 12'h01C, 0, 32'h02);
        rd("R6 no step on byte", 12'h018, 2, 1);
        cur_tag = "R5";
        wr(12'h000, 2, 32'h0);
        wr(12'h01C, 2, 32'hDEAD_0001);
        rd("R5 step off", 12'h018, 2, 1);
        rd("R5 lut1", 12'h01C, 2, 32'hDEAD_0001);
        chk("R5 lut1 port", lut_bits[63:32], 32'hDEAD_0001);

        cur_tag = "R9";
        wr(12'h018, 2, 2);
        wr(12'h01D, 0, 32'h5A);
        rd("R9 lut merge", 12'h01C, 2, 32'hC3C3_5A03);
        wr(12'h02A, 1, 32'h1);
        rd("R9 zero-extend", 12'h028, 2, 0);
        wr(12'h028, 2, 1);
        wr(12'h001, 0, 32'h01);
        rd("R9 ctrl byte", 12'h000, 2, 32'h100);
        wr(12'h000, 0, 32'h10);
        rd("R9 ctrl merge", 12'h000, 2, 32'h110);
        wr(12'h018, 0, 32'h3);
        rd("R9 idx merge", 12'h018, 2, 3);
        wr(12'h000, 2, 32'h0);

        cur_tag = "R10";
        wr(12'h018, 2, 2);
        rd("R10 half hi", 12'h01E, 1, 32'hC3C3);
        rd("R10 byte", 12'h01D, 0, 32'h5A);
        rd("R10 byte zero", 12'h011, 0, 0);
        rd("R10 byte low", 12'h010, 0, 3);
        rd("R10 clr reads 0", 12'h024, 2, 0);
        rd("R10 set reads 0", 12'h034, 2, 0);
        rd("R10 unmapped", 12'h040, 2, 0);

        cur_tag = "R11";
        wr(12'h034, 2, 1);
        rd("R11 set", 12'h020, 2, 1);
        chk("R11 irq on", {31'b0, irq}, 1);
        wr(12'h028, 2, 0);
        chk("R11 irq masked", {31'b0, irq}, 0);
        wr(12'h028, 2, 1);
        chk("R11 irq back", {31'b0, irq}, 1);
        wr(12'h024, 2, 1);
        rd("R11 clear", 12'h020, 2, 0);
        chk("R11 irq off", {31'b0, irq}, 0);
        wr(12'h034, 2, 2);
        rd("R11 bit0 only", 12'h020, 2, 0);

        cur_tag = "R12";
        viol(32'h0000_3010, 32'h0001_0042);
        rd("R12 status", 12'h020, 2, 1);
        rd("R12 info1", 12'h02C, 2, 32'h3010);
        rd("R12 info2", 12'h030, 2, 32'h0001_0042);
        chk("R12 irq", {31'b0, irq}, 1);
        viol(32'h0000_5000, 32'h7);
        rd("R12 held", 12'h02C, 2, 32'h3010);
        wr(12'h024, 2, 1);
        viol(32'h0000_5000, 32'h7);
        rd("R12 recapture1", 12'h02C, 2, 32'h5000);
        rd("R12 recapture2", 12'h030, 2, 32'h7);
        wr(12'h024, 2, 1);

        cur_tag = "R7";
        wr(12'h000, 2, 32'h100);
        rd("R7 ns read", 12'h000, 2, 0, 0);
        wr(12'h000, 2, 32'h0, 0);
        rd("R7 ns write dropped", 12'h000, 2, 32'h100);
        wr(12'h018, 2, 0);
        wr(12'h01C, 2, 32'h1234_5678, 0);
        rd("R7 no step", 12'h018, 2, 0);
        rd("R7 lut intact", 12'h01C, 0, 32'h01);
        wr(12'h034, 2, 1, 0);
        rd("R7 ns set dropped", 12'h020, 2, 0);

        cur_tag = "R8";
        wr(12'h000, 2, 32'h8000_0010);
        rd("R8 sealed", 12'h000, 2, 32'h8000_0010);
        chk("R8 locked out", {31'b0, cfg_locked}, 1);
        chk("R8 err out", {31'b0, cfg_err_resp}, 1);
        wr(12'h000, 2, 32'h0);
        rd("R8 ctrl frozen", 12'h000, 2, 32'h8000_0010);
        wr(12'h018, 2, 1);
        rd("R8 idx writable", 12'h018, 2, 1);
        wr(12'h01C, 2, 32'hFFFF_FFFF);
        rd("R8 lut frozen", 12'h01C, 0, 32'h01);
        wr(12'h028, 2, 0);
        rd("R8 en frozen", 12'h028, 2, 1);
        wr(12'h034, 2, 1);
        rd("R8 set allowed", 12'h020, 2, 1);
        wr(12'h024, 2, 1);

        cur_tag = "R1";
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        rd("R1 ctrl after reset", 12'h000, 2, 32'h100);
        chk("R1 unlock by reset", {31'b0, cfg_locked}, 0);
        rd("R1 lut after reset", 12'h01C, 0, 0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule